// File: doc/BRIEF.md
# Packed Register-Operand Instruction Decoder

This block takes one instruction word per transfer, together with a format code, and splits it into register indices and immediates. Register numbers are not plain bit fields. A 5-bit packed field carries the upper two bits of two or three operands at once, as base-3 digits. The lower two bits of each operand sit in their own 2-bit fields. The decoder extracts the digits by division and remainder by 3 and 9 and joins them with the low bits. It flags any combination that cannot name one of the twelve registers. For some formats it falls back to a wider operand grouping when the narrower one is illegal. It also expands a bit-position immediate through a fixed twelve-entry table.

The word is held in one register stage behind a valid/ready handshake. A two-state controller governs that stage:
- EMPTY → FULL (LOAD): a word is accepted.
- FULL → FULL (REFILL): a new word is accepted in the same cycle as the held result leaves.
- FULL → FULL (HOLD): the consumer stalls.
- FULL → EMPTY (DRAIN): the result leaves and no word is offered.
- EMPTY → EMPTY (IDLE): no word is offered.

Top module: `pkd_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. out_legal, out_regs and every other result output are 0.
- R2: A word accepted on a clock edge (in_valid and in_ready both 1) is presented with out_valid 1 after that edge. With out_ready 1 and no new word, out_valid falls after the next edge.
- R3: in_ready equals 1 when the stage is empty or out_ready is 1. While out_valid is 1 and out_ready is 0, every output holds its value.
- R4: Bits 7:0 of in_word carry the first stream byte, and the word is little-endian. Short formats (codes 0 to 3) read only bits 15:0, and bits 31:16 have no effect on their result.
- R5: Three-operand group (format code 2). Let c be bits 10:6. The group is legal only when c < 27. The operand indices are 4*(c mod 3)+bits 5:4, 4*((c/3) mod 3)+bits 3:2 and 4*(c/9)+bits 1:0. Register k of the result is out_regs[4k+3:4k], and out_nreg gives the count.
- R6: Two-operand group (format code 0). The group is legal when bit 5 is 0 and c < 9. The registers are then 4*(c mod 3)+bits 3:2 and 4*(c/3)+bits 1:0. Otherwise the word is read as a three-operand group, with out_fallback 1 and out_opc = bits 15:11.
- R7: Bit-position formats. In code 1, the result is one register plus an immediate index 4*(c/3)+bits 1:0, with a fallback to code 3 behaviour. In code 3, the result is two registers plus the index 4*(c/9)+bits 1:0. The index is given on out_imm. out_bitp maps indices 0..11 to 32,1,2,3,4,5,6,7,8,16,24,32, and an index of 12 or more is illegal.
- R8: Code 4 decodes a two-operand group in bits 15:0. If that group is illegal, it decodes a three-operand group with out_fallback 1 and out_opc = {bits 31:27, bits 19:16}.
- R9: Code 5 gives five registers: a three-operand group from bits 15:0, then a two-operand group from bits 31:16. If either group is illegal, it gives six registers from two three-operand groups, with out_fallback 1 and out_opc = bits 31:27.
- R10: Code 6 gives a three-operand group from bits 15:0 plus register 3 taken directly from bits 19:16. The result is illegal if bits 19:16 are 12 or more.
- R11: out_wide is 1 for codes 4 to 6 and 0 for codes 0 to 3. Code 7 is reserved, and gives an illegal result with out_wide 0.
- R12: An illegal result has out_legal 0 and zero in out_nreg, out_regs, out_imm, out_bitp, out_opc and out_fallback. In a legal result, the register slots at and above out_nreg are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Stage can take a word |
| in_word | input | 32 | Instruction bytes, first byte in bits 7:0 |
| in_fmt | input | 3 | Format code 0..7 |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result held |
| out_legal | output | 1 | Operand packing is legal |
| out_wide | output | 1 | Result came from a 32-bit format |
| out_fallback | output | 1 | The wider grouping was used |
| out_nreg | output | 3 | Number of registers |
| out_regs | output | 24 | Six 4-bit register indices |
| out_imm | output | 6 | Immediate operand index |
| out_bitp | output | 6 | Expanded bit-position value |
| out_opc | output | 9 | Opcode field for the fallback |

## Verification
Two functions can land in the same cycle. The REFILL transition takes a new word in the cycle the held result is consumed, and the HOLD transition must keep the old result while a word waits. The bench drives random in_valid and out_ready together with random words and format codes, so these cases occur again and again. A queue-free reference model predicts the fullness of the stage, in_ready and the held result every cycle. The model keeps the old result on a stall and replaces it on a refill.

// File: rtl/pkd_pkg.sv
package pkd_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int CMB_W   = 5;
    localparam int REG_W   = 4;
    localparam int NUM_REG = 6;
    localparam int REGS_W  = NUM_REG * REG_W;
    localparam int IMM_W   = 6;
    localparam int OPC_W   = 9;
    localparam int CNT_W   = 3;
    localparam int FMT_W   = 3;
    localparam int NUM_FMT = 1 << FMT_W;
    localparam int REG_LIM = 12;

    typedef enum logic [FMT_W-1:0] {
        FMT_S2  = 3'd0,
        FMT_S2B = 3'd1,
        FMT_S3  = 3'd2,
        FMT_S3B = 3'd3,
        FMT_L2  = 3'd4,
        FMT_L5  = 3'd5,
        FMT_L4  = 3'd6,
        FMT_RSV = 3'd7
    } fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } st_e;

    typedef struct packed {
        logic              legal;
        logic              wide;
        logic              fb;
        logic [CNT_W-1:0]  nreg;
        logic [REGS_W-1:0] regs;
        logic [IMM_W-1:0]  imm;
        logic [IMM_W-1:0]  bitp;
        logic [OPC_W-1:0]  opc;
    } dec_t;
endpackage

// File: rtl/pkd_split3.sv
module pkd_split3
    import pkd_pkg::*;
(
    input  logic [CMB_W-1:0] comb,
    input  logic [5:0]       low,
    output logic             ok,
    output logic [REG_W-1:0] r0,
    output logic [REG_W-1:0] r1,
    output logic [REG_W-1:0] r2
);
    logic [CMB_W-1:0] q3;
    logic [1:0]       d0, d1, d2;

    always_comb begin
        q3 = comb / CMB_W'(3);
        d0 = 2'(comb % CMB_W'(3));
        d1 = 2'(q3 % CMB_W'(3));
        d2 = 2'(comb / CMB_W'(9));
        ok = (comb < CMB_W'(27));
        r0 = {d0, low[5:4]};
        r1 = {d1, low[3:2]};
        r2 = {d2, low[1:0]};
    end
endmodule

// File: rtl/pkd_split2.sv
module pkd_split2
    import pkd_pkg::*;
(
    input  logic [CMB_W-1:0] comb,
    input  logic             ext,
    input  logic [3:0]       low,
    output logic             ok,
    output logic [REG_W-1:0] r0,
    output logic [IMM_W-1:0] idx1
);
    logic [1:0] d0;
    logic [3:0] d1;

    always_comb begin
        d0   = 2'(comb % CMB_W'(3));
        d1   = 4'(comb / CMB_W'(3));
        ok   = !ext && (comb < CMB_W'(9));
        r0   = {d0, low[3:2]};
        idx1 = {d1, low[1:0]};
    end
endmodule

// File: rtl/pkd_bitpos.sv
module pkd_bitpos
    import pkd_pkg::*;
(
    input  logic [IMM_W-1:0] idx,
    output logic             ok,
    output logic [IMM_W-1:0] val
);
    always_comb begin
        ok = 1'b1;
        if (idx == '0)
            val = IMM_W'(32);
        else if (idx <= IMM_W'(8))
            val = idx;
        else if (idx == IMM_W'(9))
            val = IMM_W'(16);
        else if (idx == IMM_W'(10))
            val = IMM_W'(24);
        else if (idx == IMM_W'(11))
            val = IMM_W'(32);
        else begin
            ok  = 1'b0;
            val = '0;
        end
    end
endmodule

// File: rtl/pkd_format.sv
module pkd_format
    import pkd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  fmt_e              fmt,
    output dec_t              res
);
    logic [1:0]                  s3ok, s2ok;
    logic [1:0][3*REG_W-1:0]     s3regs;
    logic [1:0][REG_W-1:0]       s2r0;
    logic [1:0][IMM_W-1:0]       s2i1;
    logic                        bp2ok, bp3ok;
    logic [IMM_W-1:0]            bp2v, bp3v, idx3;
    logic [REG_W-1:0]            direct;
    dec_t                        cand [NUM_FMT];

    for (genvar h = 0; h < 2; h++) begin : g_half
        pkd_split3 u_s3 (
            .comb (word[HALF_W*h+6 +: CMB_W]),
            .low  (word[HALF_W*h +: 6]),
            .ok   (s3ok[h]),
            .r0   (s3regs[h][REG_W-1:0]),
            .r1   (s3regs[h][2*REG_W-1:REG_W]),
            .r2   (s3regs[h][3*REG_W-1:2*REG_W])
        );
        pkd_split2 u_s2 (
            .comb (word[HALF_W*h+6 +: CMB_W]),
            .ext  (word[HALF_W*h+5]),
            .low  (word[HALF_W*h +: 4]),
            .ok   (s2ok[h]),
            .r0   (s2r0[h]),
            .idx1 (s2i1[h])
        );
    end

    assign idx3   = IMM_W'(s3regs[0][3*REG_W-1:2*REG_W]);
    assign direct = word[HALF_W +: REG_W];

    pkd_bitpos u_bp2 (.idx(s2i1[0]), .ok(bp2ok), .val(bp2v));
    pkd_bitpos u_bp3 (.idx(idx3),    .ok(bp3ok), .val(bp3v));

    always_comb begin
        for (int k = 0; k < NUM_FMT; k++) cand[k] = '0;

        if (s2ok[0]) begin
            cand[FMT_S2].legal = 1'b1;
            cand[FMT_S2].nreg  = CNT_W'(2);
            cand[FMT_S2].regs  = REGS_W'({s2i1[0][REG_W-1:0], s2r0[0]});
        end else if (s3ok[0]) begin
            cand[FMT_S2].legal = 1'b1;
            cand[FMT_S2].fb    = 1'b1;
            cand[FMT_S2].nreg  = CNT_W'(3);
            cand[FMT_S2].regs  = REGS_W'(s3regs[0]);
            cand[FMT_S2].opc   = OPC_W'(word[15:11]);
        end

        if (s2ok[0] && bp2ok) begin
            cand[FMT_S2B].legal = 1'b1;
            cand[FMT_S2B].nreg  = CNT_W'(1);
            cand[FMT_S2B].regs  = REGS_W'(s2r0[0]);
            cand[FMT_S2B].imm   = s2i1[0];
            cand[FMT_S2B].bitp  = bp2v;
        end else if (bp3ok) begin
            cand[FMT_S2B].legal = 1'b1;
            cand[FMT_S2B].fb    = 1'b1;
            cand[FMT_S2B].nreg  = CNT_W'(2);
            cand[FMT_S2B].regs  = REGS_W'(s3regs[0][2*REG_W-1:0]);
            cand[FMT_S2B].imm   = idx3;
            cand[FMT_S2B].bitp  = bp3v;
            cand[FMT_S2B].opc   = OPC_W'(word[15:11]);
        end

        if (s3ok[0]) begin
            cand[FMT_S3].legal = 1'b1;
            cand[FMT_S3].nreg  = CNT_W'(3);
            cand[FMT_S3].regs  = REGS_W'(s3regs[0]);
        end

        if (bp3ok) begin
            cand[FMT_S3B].legal = 1'b1;
            cand[FMT_S3B].nreg  = CNT_W'(2);
            cand[FMT_S3B].regs  = REGS_W'(s3regs[0][2*REG_W-1:0]);
            cand[FMT_S3B].imm   = idx3;
            cand[FMT_S3B].bitp  = bp3v;
        end

        cand[FMT_L2].wide = 1'b1;
        if (s2ok[0]) begin
            cand[FMT_L2].legal = 1'b1;
            cand[FMT_L2].nreg  = CNT_W'(2);
            cand[FMT_L2].regs  = REGS_W'({s2i1[0][REG_W-1:0], s2r0[0]});
        end else if (s3ok[0]) begin
            cand[FMT_L2].legal = 1'b1;
            cand[FMT_L2].fb    = 1'b1;
            cand[FMT_L2].nreg  = CNT_W'(3);
            cand[FMT_L2].regs  = REGS_W'(s3regs[0]);
            cand[FMT_L2].opc   = {word[31:27], word[19:16]};
        end

        cand[FMT_L5].wide = 1'b1;
        if (s3ok[0] && s2ok[1] && (s2i1[1][IMM_W-1:REG_W] == '0)) begin
            cand[FMT_L5].legal = 1'b1;
            cand[FMT_L5].nreg  = CNT_W'(5);
            cand[FMT_L5].regs  = REGS_W'({s2i1[1][REG_W-1:0], s2r0[1], s3regs[0]});
        end else if (s3ok[0] && s3ok[1]) begin
            cand[FMT_L5].legal = 1'b1;
            cand[FMT_L5].fb    = 1'b1;
            cand[FMT_L5].nreg  = CNT_W'(6);
            cand[FMT_L5].regs  = {s3regs[1], s3regs[0]};
            cand[FMT_L5].opc   = OPC_W'(word[31:27]);
        end

        cand[FMT_L4].wide = 1'b1;
        if (s3ok[0] && (direct < REG_W'(REG_LIM))) begin
            cand[FMT_L4].legal = 1'b1;
            cand[FMT_L4].nreg  = CNT_W'(4);
            cand[FMT_L4].regs  = REGS_W'({direct, s3regs[0]});
        end
    end

    assign res = cand[fmt];
endmodule

// File: rtl/pkd_decoder.sv
module pkd_decoder
    import pkd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    input  logic [FMT_W-1:0]    in_fmt,
    input  logic                out_ready,
    output logic                out_valid,
    output logic                out_legal,
    output logic                out_wide,
    output logic                out_fallback,
    output logic [CNT_W-1:0]    out_nreg,
    output logic [REGS_W-1:0]   out_regs,
    output logic [IMM_W-1:0]    out_imm,
    output logic [IMM_W-1:0]    out_bitp,
    output logic [OPC_W-1:0]    out_opc
);
    st_e  state, state_nx;
    dec_t dec, held;
    logic accept;

    pkd_format u_fmt (
        .word (in_word),
        .fmt  (fmt_e'(in_fmt)),
        .res  (dec)
    );

    assign in_ready = (state == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (accept) state_nx = ST_FULL;
            ST_FULL: begin
                if (accept)         state_nx = ST_FULL;
                else if (out_ready) state_nx = ST_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (accept) held <= dec;
    end

    assign out_valid    = (state == ST_FULL);
    assign out_legal    = held.legal;
    assign out_wide     = held.wide;
    assign out_fallback = held.fb;
    assign out_nreg     = held.nreg;
    assign out_regs     = held.regs;
    assign out_imm      = held.imm;
    assign out_bitp     = held.bitp;
    assign out_opc      = held.opc;
endmodule

// File: rtl/pkd_decoder_chk.sv
module pkd_decoder_chk
    import pkd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_ready,
    input logic              out_valid,
    input logic              out_legal,
    input logic              out_wide,
    input logic              out_fallback,
    input logic [CNT_W-1:0]  out_nreg,
    input logic [REGS_W-1:0] out_regs,
    input logic [IMM_W-1:0]  out_imm,
    input logic [IMM_W-1:0]  out_bitp,
    input logic [OPC_W-1:0]  out_opc
);
    logic regs_ok;

    always_comb begin
        regs_ok = 1'b1;
        for (int k = 0; k < NUM_REG; k++)
            if (out_regs[k*REG_W +: REG_W] >= REG_W'(REG_LIM)) regs_ok = 1'b0;
    end

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_regs) && $stable(out_legal)
            && $stable(out_nreg) && $stable(out_imm) && $stable(out_bitp)
            && $stable(out_opc) && $stable(out_fallback) && $stable(out_wide));

    // R3
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid && !out_ready);

    // R2
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R2
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid);

    // R12
    illegal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_legal |-> out_nreg == '0 && out_regs == '0 && !out_fallback
            && out_imm == '0 && out_bitp == '0 && out_opc == '0);

    // R5
    legal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_legal |-> regs_ok && out_nreg != '0 && out_nreg <= CNT_W'(NUM_REG));

    // R7
    bitp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bitp != '0 |-> out_legal && out_imm < IMM_W'(REG_LIM));
endmodule

bind pkd_decoder pkd_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_legal    (out_legal),
    .out_wide     (out_wide),
    .out_fallback (out_fallback),
    .out_nreg     (out_nreg),
    .out_regs     (out_regs),
    .out_imm      (out_imm),
    .out_bitp     (out_bitp),
    .out_opc      (out_opc)
);

// File: tb/pkd_decoder_bench.sv
module pkd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [2:0]  in_fmt = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_legal, out_wide, out_fallback;
    logic [2:0]  out_nreg;
    logic [23:0] out_regs;
    logic [5:0]  out_imm, out_bitp;
    logic [8:0]  out_opc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    pkd_decoder u_pkd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_fmt(in_fmt), .out_ready(out_ready),
        .out_valid(out_valid), .out_legal(out_legal), .out_wide(out_wide),
        .out_fallback(out_fallback), .out_nreg(out_nreg), .out_regs(out_regs),
        .out_imm(out_imm), .out_bitp(out_bitp), .out_opc(out_opc)
    );

    typedef struct {
        bit      legal;
        bit      wide;
        bit      fb;
        int      nreg;
        longint  regs;
        int      imm;
        int      bitp;
        int      opc;
        string   tag;
    } exp_t;

    function automatic int bpv(int i);
        if (i == 0) return 32;
        if (i <= 8) return i;
        if (i == 9) return 16;
        if (i == 10) return 24;
        if (i == 11) return 32;
        return -1;
    endfunction

    function automatic bit trio(int h, output int a0, output int a1, output int a2);
        int c = (h >> 6) & 31;
        a0 = (c % 3) * 4 + ((h >> 4) & 3);
        a1 = ((c / 3) % 3) * 4 + ((h >> 2) & 3);
        a2 = (c / 9) * 4 + (h & 3);
        return c < 27;
    endfunction

    function automatic bit pair(int h, output int p0, output int p1);
        int c = (h >> 6) & 31;
        p0 = (c % 3) * 4 + ((h >> 2) & 3);
        p1 = (c / 3) * 4 + (h & 3);
        return (((h >> 5) & 1) == 0) && (c < 9);
    endfunction

    function automatic exp_t model(bit [31:0] w, int f);
        exp_t e;
        int lo, hi, a0, a1, a2, b0, b1, b2, p0, p1, q0, q1, dr;
        bit t3l, t2l, t3h, t2h;
        lo = int'(w[15:0]);
        hi = int'(w[31:16]);
        t3l = trio(lo, a0, a1, a2);
        t2l = pair(lo, p0, p1);
        t3h = trio(hi, b0, b1, b2);
        t2h = pair(hi, q0, q1);
        dr  = int'(w[19:16]);
        e = '{legal: 0, wide: 0, fb: 0, nreg: 0, regs: 0, imm: 0, bitp: 0, opc: 0, tag: ""};
        case (f)
            0: begin
                e.tag = "R6 R4";
                if (t2l) begin
                    e.legal = 1; e.nreg = 2; e.regs = (p1 << 4) | p0;
                end else if (t3l) begin
                    e.legal = 1; e.fb = 1; e.nreg = 3;
                    e.regs = (a2 << 8) | (a1 << 4) | a0; e.opc = (lo >> 11) & 31;
                end
            end
            1: begin
                e.tag = "R7 R4";
                if (t2l && bpv(p1) >= 0) begin
                    e.legal = 1; e.nreg = 1; e.regs = p0; e.imm = p1; e.bitp = bpv(p1);
                end else if (bpv(a2) >= 0) begin
                    e.legal = 1; e.fb = 1; e.nreg = 2; e.regs = (a1 << 4) | a0;
                    e.imm = a2; e.bitp = bpv(a2); e.opc = (lo >> 11) & 31;
                end
            end
            2: begin
                e.tag = "R5 R4";
                if (t3l) begin
                    e.legal = 1; e.nreg = 3; e.regs = (a2 << 8) | (a1 << 4) | a0;
                end
            end
            3: begin
                e.tag = "R7 R4";
                if (bpv(a2) >= 0) begin
                    e.legal = 1; e.nreg = 2; e.regs = (a1 << 4) | a0;
                    e.imm = a2; e.bitp = bpv(a2);
                end
            end
            4: begin
                e.tag = "R8 R11"; e.wide = 1;
                if (t2l) begin
                    e.legal = 1; e.nreg = 2; e.regs = (p1 << 4) | p0;
                end else if (t3l) begin
                    e.legal = 1; e.fb = 1; e.nreg = 3;
                    e.regs = (a2 << 8) | (a1 << 4) | a0;
                    e.opc = (((hi >> 11) & 31) << 4) | dr;
                end
            end
            5: begin
                e.tag = "R9 R11"; e.wide = 1;
                if (t3l && t2h) begin
                    e.legal = 1; e.nreg = 5;
                    e.regs = (longint'(q1) << 16) | (q0 << 12) | (a2 << 8) | (a1 << 4) | a0;
                end else if (t3l && t3h) begin
                    e.legal = 1; e.fb = 1; e.nreg = 6;
                    e.regs = (longint'(b2) << 20) | (longint'(b1) << 16) | (b0 << 12)
                           | (a2 << 8) | (a1 << 4) | a0;
                    e.opc = (hi >> 11) & 31;
                end
            end
            6: begin
                e.tag = "R10 R11"; e.wide = 1;
                if (t3l && dr < 12) begin
                    e.legal = 1; e.nreg = 4;
                    e.regs = (dr << 12) | (a2 << 8) | (a1 << 4) | a0;
                end
            end
            default: e.tag = "R11";
        endcase
        if (!e.legal) e.tag = {e.tag, " R12"};
        return e;
    endfunction

    bit   m_full = 0;
    exp_t m_exp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_full = 0;
        end else begin
            bit acc, pop;
            acc = in_valid && (!m_full || out_ready);
            pop = m_full && out_ready;
            if (acc) begin
                m_full = 1;
                m_exp  = model(in_word, int'(in_fmt));
            end else if (pop) begin
                m_full = 0;
            end
        end
    end

    task automatic chk(input bit good, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == m_full, "R2", "out_valid", out_valid, m_full);
            chk(in_ready == (!m_full || out_ready), "R3", "in_ready", in_ready, !m_full || out_ready);
            if (m_full) begin
                chk(out_legal == m_exp.legal, m_exp.tag, "legal", out_legal, m_exp.legal);
                chk(out_wide == m_exp.wide, m_exp.tag, "wide", out_wide, m_exp.wide);
                chk(out_fallback == m_exp.fb, m_exp.tag, "fallback", out_fallback, m_exp.fb);
                chk(int'(out_nreg) == m_exp.nreg, m_exp.tag, "nreg", out_nreg, m_exp.nreg);
                chk(longint'(out_regs) == m_exp.regs, m_exp.tag, "regs", out_regs, m_exp.regs);
                chk(int'(out_imm) == m_exp.imm, m_exp.tag, "imm", out_imm, m_exp.imm);
                chk(int'(out_bitp) == m_exp.bitp, m_exp.tag, "bitp", out_bitp, m_exp.bitp);
                chk(int'(out_opc) == m_exp.opc, m_exp.tag, "opc", out_opc, m_exp.opc);
            end
        end
    end

    task automatic cyc(input bit v, input bit [31:0] w, input int f, input bit r);
        @(posedge clk);
        #1;
        in_valid  = v;
        in_word   = w;
        in_fmt    = 3'(f);
        out_ready = r;
    endtask

    task automatic send(input int f, input bit [31:0] w);
        cyc(1, w, f, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: state after reset
        chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
        chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
        chk(out_legal == 0, "R1", "out_legal", out_legal, 0);
        chk(out_regs == 0, "R1", "out_regs", out_regs, 0);
        chk(out_nreg == 0 && out_bitp == 0 && out_opc == 0, "R1", "result fields",
            {out_nreg, out_bitp, out_opc}, 0);
        @(posedge clk);
        #1 rst_n = 1;

        // R5 / R4: three-operand group, limits and ignored upper half
        send(2, 32'h0000_0000);
        send(2, 32'h0000_06B9);
        send(2, 32'h0000_06C0);
        send(2, 32'hFFFF_06B9);
        // R6: two-operand group and its fallback
        send(0, 32'h0000_0207);
        send(0, 32'h0000_A826);
        send(0, 32'h0000_0240);
        send(0, 32'h0000_07A0);
        // R7: bit-position formats
        send(1, 32'h0000_00C6);
        send(1, 32'h0000_0000);
        send(1, 32'h0000_0240);
        send(3, 32'h0000_0533);
        send(3, 32'h0000_0531);
        send(3, 32'h0000_0700);
        // R8, R9, R10, R11: long and reserved codes
        send(4, 32'h1234_0207);
        send(4, 32'hF8B4_0240);
        send(5, 32'h0207_06B9);
        send(5, 32'h06B9_06B9);
        send(5, 32'h06C0_0000);
        send(6, 32'h000B_06B9);
        send(6, 32'h000C_06B9);
        send(7, 32'h0000_0000);

        // R3: stall with a word waiting, then release
        cyc(1, 32'h0000_06B9, 2, 0);
        cyc(1, 32'h0000_0207, 0, 0);
        cyc(1, 32'h0000_0207, 0, 0);
        cyc(1, 32'h0000_0207, 0, 1);
        cyc(0, 32'h0, 0, 1);
        cyc(0, 32'h0, 0, 1);

        // R2 / R3: random traffic with refill, hold and drain
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] w;
            w = $urandom;
            if (($urandom % 4) == 0) w[10:6] = 5'($urandom % 9);
            if (($urandom % 4) == 0) w[26:22] = 5'($urandom % 9);
            if (($urandom % 2) == 0) w[5] = 1'b0;
            cyc(($urandom % 3) != 0, w, int'($urandom % 8), ($urandom % 3) != 0);
        end
        cyc(0, 32'h0, 0, 1);
        cyc(0, 32'h0, 0, 1);
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule